// File: doc/BRIEF.md
# I2C Target to Register-Bus Bridge

The bridge is an I2C target that turns framed I2C transactions into single 32-bit accesses on an internal register bus. Every access starts with a 4-byte command word, sent most significant byte first. The command word carries an opcode, four byte-lane enables and a 10-bit dword index. It also selects where on the bus the access goes. Depending on a build parameter, that destination is either a 5-bit port number or a 3-bit port number together with a station number and a port mode.

A register write is one I2C write transaction of eight bytes: the command word, then the data word, both big-endian. The bridge starts the bus write only after the stop condition has closed a transaction of exactly eight bytes.

A register read is a 4-byte command write, followed by a repeated start and a 4-byte I2C read. The bus read is launched as soon as the fourth command byte has arrived. The captured word is shifted out most significant bit first. The bus side is a simple master. It raises a request with all access fields and holds them until the target pulses acknowledge; read data is taken on that pulse.

Top module: `i2c_reg_bridge`

## Requirements
- R1: The bridge acknowledges only the 7-bit address given by parameter TARGET_ADDR. For any other address it leaves SDA released and makes no bus request.
- R2: A write transaction of exactly 8 bytes followed by stop, whose command bits 26:24 equal 3, produces exactly one bus request with we=1. The request carries idx = command bits 9:0, byte enables = command bits 13:10 (bit 10 is lane 0) and write data = bytes 5..8, the first of them being the most significant. The request is raised only after stop.
- R3: With LAYOUT_B=0, the bus port equals command bits 19:15, station and mode are 0, and command bits 23:20 are ignored.
- R4: With LAYOUT_B=1, the bus mode equals command bits 21:20, the station equals command bits 19:18, and the port equals command bits 17:15, zero-extended to 5 bits.
- R5: A 4-byte command with opcode 4, then a repeated start and a read of 4 bytes, produces one bus request with we=0 and the command's fields. The bridge returns the acknowledged read data most significant byte first.
- R6: A command whose opcode is neither 3 nor 4 produces no bus request, and a subsequent read returns 0xFFFFFFFF.
- R7: A write transaction that ends with fewer or more than 8 bytes, or that is broken by a repeated start, produces no bus write.
- R8: A bus request holds all its fields stable until acknowledge, drops in the cycle after acknowledge, and is issued once per access.
- R9: After reset, SDA is released and no bus request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_port_o | output | 5 | Target port number |
| bus_stn_o | output | 2 | Station number |
| bus_mode_o | output | 2 | Port mode |
| bus_idx_o | output | 10 | Dword index within the port's 4 KB space |
| bus_be_o | output | 4 | Byte-lane enables, bit 0 = lane 0 |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | One-cycle acknowledge from the register bus |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
SCL and SDA pass through a two-flop synchronizer, and edges and start/stop are detected one flop later. Every line event therefore reaches the state machine about three clocks late, and SDA is driven or released about four clocks after the SCL fall that ordered it. The bench keeps five clocks between every line change, so this delay is absorbed. It samples SDA a full quarter period after SCL rises.

A write request rises one cycle after the stop is detected, and a read request two cycles after the fourth command byte completes. The bench's bus models acknowledge after three cycles. Every bus-side check is made only after the stop condition plus ten further clocks, when any request must already have been acknowledged. Read data is compared at the host after the byte has been shifted out.

// File: rtl/i2c_bridge_pkg.sv
package i2c_bridge_pkg;
  localparam int CMD_W  = 32;
  localparam int IDX_W  = 10;
  localparam int BE_W   = 4;
  localparam int PORT_W = 5;
  localparam int STN_W  = 2;
  localparam int MODE_W = 2;
  localparam int OP_W   = 3;

  localparam logic [OP_W-1:0] OP_WR = 3'd3;
  localparam logic [OP_W-1:0] OP_RD = 3'd4;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [BE_W-1:0]   be;
    logic [IDX_W-1:0]  idx;
    logic [PORT_W-1:0] port;
    logic [STN_W-1:0]  stn;
    logic [MODE_W-1:0] mode;
  } cmd_fields_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_RX, ST_ACK_R, ST_TX, ST_ACK_M, ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_sync_q, sda_sync_q;
  logic       scl_prev_q, sda_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= 2'b11;
      sda_sync_q <= 2'b11;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[0], scl_i};
      sda_sync_q <= {sda_sync_q[0], sda_i};
      scl_prev_q <= scl_sync_q[1];
      sda_prev_q <= sda_sync_q[1];
    end
  end

  assign scl_s_o    = scl_sync_q[1];
  assign sda_s_o    = sda_sync_q[1];
  assign scl_rise_o = !scl_prev_q && scl_s_o;
  assign scl_fall_o = scl_prev_q && !scl_s_o;
  // SDA moving while SCL stays high marks a frame boundary
  assign start_o    = scl_prev_q && scl_s_o && sda_prev_q && !sda_s_o;
  assign stop_o     = scl_prev_q && scl_s_o && !sda_prev_q && sda_s_o;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm import i2c_bridge_pkg::*; #(
  parameter logic [6:0] TARGET_ADDR = 7'h2A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_s_i,
  input  logic        sda_s_i,
  input  logic        scl_rise_i,
  input  logic        scl_fall_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic [31:0] tx_word_i,
  output logic        sda_oe_o,
  output logic        rx_valid_o,
  output logic [7:0]  rx_byte_o
);
  localparam int TX_BYTES = 4;

  tgt_state_e  st_q;
  logic [3:0]  bit_cnt_q;
  logic [7:0]  sh_q;
  logic [31:0] tx_q;
  logic        rw_q, mack_q, oe_q, rx_valid_q;
  logic [2:0]  nbyte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      oe_q       <= 1'b0;
      rx_valid_q <= 1'b0;
      nbyte_q    <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      if (start_i) begin
        st_q      <= ST_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise_i) begin
              sh_q      <= {sh_q[6:0], sda_s_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              if (st_q == ST_RX) begin
                rx_valid_q <= 1'b1;
                oe_q       <= 1'b1;
                st_q       <= ST_ACK_R;
              end else if (sh_q[7:1] == TARGET_ADDR) begin
                oe_q <= 1'b1;
                rw_q <= sh_q[0];
                st_q <= ST_ACK_A;
              end else begin
                st_q <= ST_IGNORE;
              end
            end
          end
          ST_ACK_A: if (scl_fall_i) begin
            bit_cnt_q <= '0;
            nbyte_q   <= '0;
            if (rw_q) begin
              tx_q <= tx_word_i;
              oe_q <= !tx_word_i[31];
              st_q <= ST_TX;
            end else begin
              oe_q <= 1'b0;
              st_q <= ST_RX;
            end
          end
          ST_ACK_R: if (scl_fall_i) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            st_q      <= ST_RX;
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (bit_cnt_q == 4'd8) begin
                oe_q <= 1'b0;
                st_q <= ST_ACK_M;
              end else begin
                tx_q <= tx_q << 1;
                oe_q <= !tx_q[30];
              end
            end
          end
          ST_ACK_M: begin
            if (scl_rise_i) begin
              mack_q  <= !sda_s_i;
              nbyte_q <= nbyte_q + 3'd1;
            end else if (scl_fall_i) begin
              if (mack_q && nbyte_q < 3'(TX_BYTES)) begin
                tx_q      <= tx_q << 1;
                oe_q      <= !tx_q[30];
                bit_cnt_q <= '0;
                st_q      <= ST_TX;
              end else begin
                st_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_byte_o  = sh_q;

  // SDA is only ever pulled low while SCL is low
  p_drive_on_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_s_i);
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode import i2c_bridge_pkg::*; #(
  parameter bit LAYOUT_B = 1'b0
) (
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_fields_t      fields_o
);
  logic unused_bits;

  always_comb begin
    fields_o.op  = cmd_i[26:24];
    fields_o.be  = cmd_i[13:10];
    fields_o.idx = cmd_i[IDX_W-1:0];
  end

  generate
    if (LAYOUT_B) begin : g_layout_b
      always_comb begin
        fields_o.mode = cmd_i[21:20];
        fields_o.stn  = cmd_i[19:18];
        fields_o.port = {2'b00, cmd_i[17:15]};
      end
      assign unused_bits = ^{cmd_i[31:27], cmd_i[23:22], cmd_i[14]};
    end else begin : g_layout_a
      always_comb begin
        fields_o.mode = '0;
        fields_o.stn  = '0;
        fields_o.port = cmd_i[19:15];
      end
      assign unused_bits = ^{cmd_i[31:27], cmd_i[23:20], cmd_i[14]};
    end
  endgenerate
endmodule

// File: rtl/reg_bus_master.sv
module reg_bus_master import i2c_bridge_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_rd_i,
  input  logic              issue_wr_i,
  input  logic              fill_ones_i,
  input  cmd_fields_t       fields_i,
  input  logic [31:0]       wdata_i,
  input  logic              ack_i,
  input  logic [31:0]       rdata_i,
  output logic              req_o,
  output logic              we_o,
  output logic [PORT_W-1:0] port_o,
  output logic [STN_W-1:0]  stn_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BE_W-1:0]   be_o,
  output logic [31:0]       wdata_o,
  output logic [31:0]       rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      port_o  <= '0;
      stn_o   <= '0;
      mode_o  <= '0;
      idx_o   <= '0;
      be_o    <= '0;
      wdata_o <= '0;
      rdata_o <= '1;
    end else if (req_o) begin
      if (ack_i) begin
        req_o <= 1'b0;
        if (!we_o) rdata_o <= rdata_i;
      end
    end else begin
      if (fill_ones_i) rdata_o <= '1;
      if (issue_rd_i || issue_wr_i) begin
        req_o   <= 1'b1;
        we_o    <= issue_wr_i;
        port_o  <= fields_i.port;
        stn_o   <= fields_i.stn;
        mode_o  <= fields_i.mode;
        idx_o   <= fields_i.idx;
        be_o    <= fields_i.be;
        wdata_o <= wdata_i;
      end
    end
  end

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable({we_o, port_o, stn_o, mode_o, idx_o, be_o, wdata_o})));

  p_req_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> !req_o);
endmodule

// File: rtl/i2c_reg_bridge.sv
module i2c_reg_bridge import i2c_bridge_pkg::*; #(
  parameter logic [6:0] TARGET_ADDR = 7'h2A,
  parameter bit         LAYOUT_B    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [PORT_W-1:0] bus_port_o,
  output logic [STN_W-1:0]  bus_stn_o,
  output logic [MODE_W-1:0] bus_mode_o,
  output logic [IDX_W-1:0]  bus_idx_o,
  output logic [BE_W-1:0]   bus_be_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [31:0]       bus_rdata_i
);
  localparam int          CMD_BYTES = CMD_W / 8;
  localparam int          WR_BYTES  = CMD_BYTES + 4;
  localparam logic [3:0]  CNT_SAT   = 4'(WR_BYTES + 1);

  logic        scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic [31:0] rdata_q;
  logic [3:0]  rx_cnt_q;
  logic [31:0] cmd_q, wdata_q;
  logic        cmd_done_q;
  logic        issue_rd, issue_wr, fill_ones;
  cmd_fields_t fields;

  i2c_line_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_w), .stop_o(stop_w)
  );

  i2c_target_fsm #(.TARGET_ADDR(TARGET_ADDR)) u_fsm (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_w), .stop_i(stop_w), .tx_word_i(rdata_q),
    .sda_oe_o, .rx_valid_o(rx_valid), .rx_byte_o(rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cnt_q   <= '0;
      cmd_q      <= '0;
      wdata_q    <= '0;
      cmd_done_q <= 1'b0;
    end else begin
      cmd_done_q <= rx_valid && rx_cnt_q == 4'(CMD_BYTES - 1);
      if (start_w) begin
        rx_cnt_q <= '0;
      end else if (rx_valid) begin
        if (rx_cnt_q < 4'(CMD_BYTES))     cmd_q   <= {cmd_q[23:0], rx_byte};
        else if (rx_cnt_q < 4'(WR_BYTES)) wdata_q <= {wdata_q[23:0], rx_byte};
        if (rx_cnt_q != CNT_SAT) rx_cnt_q <= rx_cnt_q + 4'd1;
      end
    end
  end

  cmd_decode #(.LAYOUT_B(LAYOUT_B)) u_dec (.cmd_i(cmd_q), .fields_o(fields));

  // write waits for a stop that closes exactly eight bytes; read starts on the command alone
  assign issue_wr  = stop_w && rx_cnt_q == 4'(WR_BYTES) && fields.op == OP_WR;
  assign issue_rd  = cmd_done_q && fields.op == OP_RD;
  assign fill_ones = cmd_done_q && fields.op != OP_RD;

  reg_bus_master u_bus (
    .clk_i, .rst_ni,
    .issue_rd_i(issue_rd), .issue_wr_i(issue_wr), .fill_ones_i(fill_ones),
    .fields_i(fields), .wdata_i(wdata_q),
    .ack_i(bus_ack_i), .rdata_i(bus_rdata_i),
    .req_o(bus_req_o), .we_o(bus_we_o), .port_o(bus_port_o),
    .stn_o(bus_stn_o), .mode_o(bus_mode_o), .idx_o(bus_idx_o),
    .be_o(bus_be_o), .wdata_o(bus_wdata_o), .rdata_o(rdata_q)
  );

  p_write_after_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bus_req_o) && bus_we_o) |-> $past(stop_w));

  p_read_after_cmd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bus_req_o) && !bus_we_o) |-> $past(cmd_done_q));
endmodule

// File: tb/i2c_reg_bridge_test.sv
module i2c_reg_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam logic [6:0] ADDR_A = 7'h2A;
  localparam logic [6:0] ADDR_B = 7'h3B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  int   n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic oe_a, req_a, we_a, ack_a;
  logic [4:0] port_a; logic [1:0] stn_a, mode_a; logic [9:0] idx_a; logic [3:0] be_a;
  logic [31:0] wd_a, rd_a;
  logic oe_b, req_b, we_b, ack_b;
  logic [4:0] port_b; logic [1:0] stn_b, mode_b; logic [9:0] idx_b; logic [3:0] be_b;
  logic [31:0] wd_b, rd_b;

  assign sda_line = sda_m & ~oe_a & ~oe_b;

  function automatic logic [31:0] rd_model(logic [4:0] p, logic [1:0] s, logic [1:0] m, logic [9:0] i);
    if ({p, s, m, i} == '0) return 32'hC0DE1A2B;
    return {m, s, p, 3'b101, i, i ^ 10'h2AA};
  endfunction

  assign rd_a = rd_model(port_a, stn_a, mode_a, idx_a);
  assign rd_b = rd_model(port_b, stn_b, mode_b, idx_b);

  i2c_reg_bridge #(.TARGET_ADDR(ADDR_A), .LAYOUT_B(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(oe_a),
    .bus_req_o(req_a), .bus_we_o(we_a), .bus_port_o(port_a), .bus_stn_o(stn_a),
    .bus_mode_o(mode_a), .bus_idx_o(idx_a), .bus_be_o(be_a), .bus_wdata_o(wd_a),
    .bus_ack_i(ack_a), .bus_rdata_i(rd_a));

  i2c_reg_bridge #(.TARGET_ADDR(ADDR_B), .LAYOUT_B(1'b1)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(oe_b),
    .bus_req_o(req_b), .bus_we_o(we_b), .bus_port_o(port_b), .bus_stn_o(stn_b),
    .bus_mode_o(mode_b), .bus_idx_o(idx_b), .bus_be_o(be_b), .bus_wdata_o(wd_b),
    .bus_ack_i(ack_b), .bus_rdata_i(rd_b));

  // bus models: ack after three cycles, log the request at ack
  int na = 0, nb = 0;
  logic [55:0] log_a, log_b;
  int dly_a = 0, dly_b = 0;
  always @(posedge clk) begin
    ack_a <= 1'b0;
    if (rst_n && req_a && !ack_a) begin
      if (dly_a == 2) begin
        ack_a <= 1'b1; dly_a <= 0; na <= na + 1;
        log_a <= {we_a, port_a, stn_a, mode_a, idx_a, be_a, wd_a};
      end else dly_a <= dly_a + 1;
    end
  end
  always @(posedge clk) begin
    ack_b <= 1'b0;
    if (rst_n && req_b && !ack_b) begin
      if (dly_b == 2) begin
        ack_b <= 1'b1; dly_b <= 0; nb <= nb + 1;
        log_b <= {we_b, port_b, stn_b, mode_b, idx_b, be_b, wd_b};
      end else dly_b <= dly_b + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    waitq(Q); sda_m = b; waitq(Q); scl_m = 1'b1; waitq(2*Q); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; waitq(2*Q); scl_m = 1'b1; waitq(Q); b = sda_line; waitq(Q); scl_m = 1'b0;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; waitq(Q); scl_m = 1'b1; waitq(Q); sda_m = 1'b0; waitq(Q); scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitq(Q); scl_m = 1'b1; waitq(Q); sda_m = 1'b1; waitq(2*Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    acked = !a;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(!give_ack);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [31:0] cmd, input logic [31:0] dat,
                          input int nbytes, input logic rep_start, output logic acked);
    logic [63:0] frame;
    logic k_ack;
    frame = {cmd, dat};
    i2c_start();
    wr_byte({a, 1'b0}, acked);
    for (int k = 0; k < nbytes; k++)
      wr_byte((k < 8) ? frame[63-8*k -: 8] : 8'h00, k_ack);
    if (rep_start) begin
      i2c_start();
      wr_byte({a, 1'b0}, k_ack);
    end
    i2c_stop();
    waitq(10);
  endtask

  task automatic do_read(input logic [6:0] a, input logic [31:0] cmd, output logic [31:0] dat);
    logic k_ack;
    i2c_start();
    wr_byte({a, 1'b0}, k_ack);
    for (int k = 0; k < 4; k++) wr_byte(cmd[31-8*k -: 8], k_ack);
    i2c_start();
    wr_byte({a, 1'b1}, k_ack);
    for (int k = 0; k < 4; k++) rd_byte(k < 3, dat[31-8*k -: 8]);
    i2c_stop();
    waitq(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic acked;
    logic [31:0] cmd, dat, rdv;
    int na0, nb0;
    waitq(5);
    rst_n = 1'b1;
    waitq(3);
    // R9: idle after reset
    chk("R9 reset sda/req", {oe_a, oe_b, req_a, req_b}, 4'b0000);

    // R1: foreign address not acknowledged, no bus activity
    na0 = na; nb0 = nb;
    do_write(7'h11, {5'b0, 3'd3, 24'h00FC05}, 32'h12345678, 8, 1'b0, acked);
    chk("R1 foreign addr nack", acked, 1'b0);
    chk("R1 foreign addr no request", {na - na0, nb - nb0}, 64'd0);

    // R2/R3/R8: layout A writes, sweep all byte-enable patterns, junk in bits 23:20
    for (int be = 0; be < 16; be++) begin
      logic [4:0] p; logic [9:0] ix;
      p = 5'(be * 2 + 1); ix = 10'(be * 37 + 3);
      cmd = {5'b0, 3'd3, 4'hA, p, 1'b0, 4'(be), ix};
      dat = (32'h01020304 * 32'(be + 1)) ^ {4'(be), 28'h0};
      na0 = na; nb0 = nb;
      do_write(ADDR_A, cmd, dat, 8, 1'b0, acked);
      chk("R1 own addr ack", acked, 1'b1);
      chk("R8 one request per write", {na - na0, nb - nb0}, {32'd1, 32'd0});
      chk("R2 R3 write fields layout A", log_a, {1'b1, p, 2'b00, 2'b00, ix, 4'(be), dat});
    end

    // R4: layout B writes, sweep mode x station
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [2:0] p; logic [9:0] ix;
        p = 3'((m * 4 + s) % 8); ix = 10'(m * 200 + s * 17 + 1);
        cmd = {5'b0, 3'd3, 2'b00, 2'(m), 2'(s), p, 1'b0, 4'hF, ix};
        dat = {8'(m), 8'(s), 16'hBEAD};
        nb0 = nb;
        do_write(ADDR_B, cmd, dat, 8, 1'b0, acked);
        chk("R4 one request layout B", nb - nb0, 1);
        chk("R4 write fields layout B", log_b, {1'b1, 2'b00, p, 2'(s), 2'(m), ix, 4'hF, dat});
      end
    end

    // R5: layout A reads, including port 0 register 0 identification word
    begin
      logic [4:0] pa[4]; logic [9:0] ia[4];
      pa = '{5'd0, 5'd3, 5'd17, 5'd31}; ia = '{10'd0, 10'd100, 10'd1023, 10'd512};
      for (int r = 0; r < 4; r++) begin
        cmd = {5'b0, 3'd4, 4'h0, pa[r], 1'b0, 4'hF, ia[r]};
        na0 = na;
        do_read(ADDR_A, cmd, rdv);
        chk("R5 read data layout A", rdv, rd_model(pa[r], 2'b00, 2'b00, ia[r]));
        chk("R5 read request layout A", {32'(na - na0), 24'h0, log_a[55]}, {32'd1, 24'h0, 1'b0});
        chk("R5 R3 read fields layout A", log_a[54:32], {pa[r], 2'b00, 2'b00, ia[r], 4'hF});
      end
    end

    // R5/R4: layout B reads
    for (int r = 0; r < 4; r++) begin
      logic [2:0] p; logic [9:0] ix;
      p = 3'(7 - r); ix = 10'(r * 255);
      cmd = {5'b0, 3'd4, 2'b00, 2'(r), 2'(3 - r), p, 1'b0, 4'hF, ix};
      do_read(ADDR_B, cmd, rdv);
      chk("R5 R4 read data layout B", rdv, rd_model({2'b00, p}, 2'(3 - r), 2'(r), ix));
    end

    // R6: unknown opcodes
    na0 = na;
    do_write(ADDR_A, {5'b0, 3'd5, 24'h00FC01}, 32'hDEADDEAD, 8, 1'b0, acked);
    chk("R6 opcode 5 no request", na - na0, 0);
    do_read(ADDR_A, {5'b0, 3'd0, 24'h00FC02}, rdv);
    chk("R6 opcode 0 read ones", rdv, 32'hFFFFFFFF);
    chk("R6 opcode 0 no request", na - na0, 0);

    // R7: truncated or over-long writes, and write broken by repeated start
    na0 = na;
    do_write(ADDR_A, {5'b0, 3'd3, 24'h00FC07}, 32'h11111111, 7, 1'b0, acked);
    chk("R7 seven bytes no write", na - na0, 0);
    do_write(ADDR_A, {5'b0, 3'd3, 24'h00FC08}, 32'h22222222, 9, 1'b0, acked);
    chk("R7 nine bytes no write", na - na0, 0);
    do_write(ADDR_A, {5'b0, 3'd3, 24'h00FC09}, 32'h33333333, 8, 1'b1, acked);
    chk("R7 repeated start no write", na - na0, 0);

    // R2: a clean write still works afterwards
    do_write(ADDR_A, {5'b0, 3'd3, 4'h0, 5'd9, 1'b0, 4'h5, 10'd77}, 32'hCAFEF00D, 8, 1'b0, acked);
    chk("R2 write after aborted ones", log_a, {1'b1, 5'd9, 2'b00, 2'b00, 10'd77, 4'h5, 32'hCAFEF00D});
    chk("R9 idle after traffic", {oe_a, oe_b, req_a, req_b}, 4'b0000);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule